// File: doc/BRIEF.md
# Shared Interrupt Hub for a Six-Port PHY

The block gathers interrupt conditions from six PHY ports and folds them into one shared, active-low interrupt output. Each port carries two management registers: a control register that holds a master enable and one mask bit per condition, and a status register that holds one sticky bit per condition. The block watches each port's autonegotiation-done flag together with its speed, duplex and link state. It detects a change from one cycle to the next and latches that change into the port's status register.

Because the shared output carries no port identity, software that sees it low has to poll the status register of every port. Reading a status register returns the pending bits and clears them in the same access. The output stays low as long as any enabled port still has an unmasked pending bit.

Top module: `phy_irq_hub`

## Requirements
- R1: After synchronous reset, `irq_n` is 1 and every port's control and status registers read 0.
- R2: Register address 18 is the control register. Bit 1 is the port master enable and bits 4..7 are the mask bits for autonegotiation, speed, duplex and link. A write stores only these five bits, and every other bit reads 0.
- R3: Register address 19 is the status register. Bit 4 is autonegotiation complete, bit 5 speed change, bit 6 duplex change and bit 7 link change. All other bits read 0.
- R4: A speed, duplex or link input that differs from its value in the previous cycle sets its status bit at the next clock edge. Two or more conditions can be set at the same edge.
- R5: Autonegotiation complete is set only by a 0-to-1 transition of the done flag. A 1-to-0 transition sets nothing.
- R6: Status bits stay set until register 19 of that port is read. The read returns the value from before the clear, and the bits are 0 afterwards.
- R7: An event that arrives in the same cycle as a read of that port's status register is set again after the clear, so the event is not lost.
- R8: A port requests an interrupt only when its master enable is 1 and at least one pending status bit has its mask bit set. Status bits are latched even while the port is masked or disabled.
- R9: `irq_n` goes low one cycle after any port request appears. It returns high one cycle after the last request from any port is gone.
- R10: Writes to register 19 or to any address other than 18 have no effect. Reads of other addresses, and any access to a port index of 6 or 7, return 0.
- R11: `reg_rdata` updates on the clock edge that samples `reg_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| an_done | input | NUM_PORTS | Per-port autonegotiation-done flag |
| speed_st | input | NUM_PORTS | Per-port current speed state |
| duplex_st | input | NUM_PORTS | Per-port current duplex state |
| link_st | input | NUM_PORTS | Per-port current link state |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_port | input | PORT_W | Port index of the access |
| reg_addr | input | 5 | Register address within the port |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The assertions assume that the state inputs and the strobes are synchronous to `clk` and that `reg_wr` and `reg_rd` are never high in the same cycle. The stuck-status and quiet-input properties also assume that the per-port state only changes when a real event is meant. The stimulus changes every input on the falling edge and issues one access per cycle. It drives the state inputs only as needed to create the intended events, including the case where an event coincides with a status read.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int REG_W      = 16;
    localparam int ADDR_W     = 5;
    localparam int NUM_EVT    = 4;
    localparam int MASTER_BIT = 1;
    localparam int EVT_LSB    = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'd18;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 5'd19;

    localparam int EVB_ANEG   = 0;
    localparam int EVB_SPEED  = 1;
    localparam int EVB_DUPLEX = 2;
    localparam int EVB_LINK   = 3;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic an_done;
        logic speed;
        logic duplex;
        logic link;
    } phy_state_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } reg_req_t;

    typedef struct packed {
        logic     master;
        evt_vec_t mask;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == ADDR_CTRL)      return SEL_CTRL;
        else if (a == ADDR_STAT) return SEL_STAT;
        else                     return SEL_NONE;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w                     = '0;
        w[MASTER_BIT]         = c.master;
        w[EVT_LSB +: NUM_EVT] = c.mask;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.master = w[MASTER_BIT];
        c.mask   = w[EVT_LSB +: NUM_EVT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input evt_vec_t s);
        logic [REG_W-1:0] w;
        w                     = '0;
        w[EVT_LSB +: NUM_EVT] = s;
        return w;
    endfunction

endpackage

// File: rtl/irq_change_detect.sv
module irq_change_detect
    import irq_hub_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phy_state_t cur,
    output evt_vec_t   evt
);

    phy_state_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= cur;
        else     prev_q <= cur;
    end

    always_comb begin
        evt             = '0;
        evt[EVB_ANEG]   = cur.an_done & ~prev_q.an_done;
        evt[EVB_SPEED]  = cur.speed  ^ prev_q.speed;
        evt[EVB_DUPLEX] = cur.duplex ^ prev_q.duplex;
        evt[EVB_LINK]   = cur.link   ^ prev_q.link;
    end

    // R4: an input held steady produces no event
    a_r4_quiet_input: assert property (@(posedge clk) disable iff (rst)
        (cur == $past(cur)) |-> (evt == '0));

    // R5: a falling done flag never raises the autonegotiation event
    a_r5_fall_ignored: assert property (@(posedge clk) disable iff (rst)
        $fell(cur.an_done) |-> !evt[EVB_ANEG]);

endmodule

// File: rtl/irq_port_regs.sv
module irq_port_regs
    import irq_hub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  reg_req_t         req,
    input  evt_vec_t         evt,
    output logic             request,
    output logic [REG_W-1:0] rd_word
);

    ctrl_t    ctrl_q;
    evt_vec_t stat_q;
    reg_sel_e which;
    logic     ctrl_we;
    logic     stat_clr;

    assign which    = decode_addr(req.addr);
    assign ctrl_we  = sel && req.wr && (which == SEL_CTRL);
    assign stat_clr = sel && req.rd && (which == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= unpack_ctrl(req.wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_clr ? evt_vec_t'('0) : stat_q) | evt;
        end
    end

    assign request = ctrl_q.master && |(stat_q & ctrl_q.mask);

    always_comb begin
        unique case (which)
            SEL_CTRL: rd_word = pack_ctrl(ctrl_q);
            SEL_STAT: rd_word = pack_status(stat_q);
            default:  rd_word = '0;
        endcase
    end

    // R6: pending bits survive any cycle without a status read
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R7: every event is latched, even during a clearing read
    a_r7_event_kept: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

    // R10: only a write to the control address alters the control register
    a_r10_ctrl_guard: assert property (@(posedge clk) disable iff (rst)
        !(sel && req.wr && req.addr == ADDR_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/irq_pin_merge.sv
module irq_pin_merge #(
    parameter int NUM_PORTS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] port_req,
    output logic                 irq_n
);

    logic any_req;

    assign any_req = |port_req;

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= ~any_req;
    end

    // R9: a request pulls the pin low on the next edge
    a_r9_assert: assert property (@(posedge clk) disable iff (rst)
        (port_req != '0) |=> !irq_n);

    // R9: the pin releases only once no port requests
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (port_req == '0) |=> irq_n);

endmodule

// File: rtl/phy_irq_hub.sv
module phy_irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] an_done,
    input  logic [NUM_PORTS-1:0] speed_st,
    input  logic [NUM_PORTS-1:0] duplex_st,
    input  logic [NUM_PORTS-1:0] link_st,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [PORT_W-1:0]    reg_port,
    input  logic [4:0]           reg_addr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    output logic                 irq_n
);

    reg_req_t             bus;
    logic [NUM_PORTS-1:0] sel;
    logic [NUM_PORTS-1:0] port_req;
    logic [REG_W-1:0]     rd_word [NUM_PORTS];
    logic [REG_W-1:0]     rd_mux;

    assign bus = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, wdata: reg_wdata};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        phy_state_t st;
        evt_vec_t   ev;

        assign st = '{an_done: an_done[p], speed: speed_st[p],
                      duplex: duplex_st[p], link: link_st[p]};
        assign sel[p] = (reg_port == PORT_W'(p));

        irq_change_detect u_det (
            .clk (clk),
            .rst (rst),
            .cur (st),
            .evt (ev)
        );

        irq_port_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel[p]),
            .req     (bus),
            .evt     (ev),
            .request (port_req[p]),
            .rd_word (rd_word[p])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel[p]) rd_mux = rd_mux | rd_word[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    irq_pin_merge #(.NUM_PORTS(NUM_PORTS)) u_pin (
        .clk      (clk),
        .rst      (rst),
        .port_req (port_req),
        .irq_n    (irq_n)
    );

    // R11: read data moves only on a read strobe
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/tb_phy_irq_hub.sv
`timescale 1ns/1ps
module tb_phy_irq_hub;

    localparam int P = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [P-1:0] an, spd, dup, lnk;
    logic         wr, rd;
    logic [2:0]   port;
    logic [4:0]   addr;
    logic [15:0]  wdata;
    logic [15:0]  rdata;
    logic         irq_n;

    always #2.5 clk = ~clk;

    phy_irq_hub #(.NUM_PORTS(P)) dut (
        .clk(clk), .rst(rst), .an_done(an), .speed_st(spd), .duplex_st(dup),
        .link_st(lnk), .reg_wr(wr), .reg_rd(rd), .reg_port(port),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_n(irq_n)
    );

    int vectors = 0;
    int errs    = 0;

    logic [15:0]  m_en [P];
    logic [15:0]  m_st [P];
    logic [P-1:0] p_an, p_spd, p_dup, p_lnk;
    logic         m_pin;
    string        cur_tag;
    logic [15:0]  expq [$];
    string        tagq [$];

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference model of one clock edge, from the requirements
    task automatic model_edge();
        logic        any;
        logic [15:0] ev;
        logic [15:0] e;
        if (rst) begin
            for (int p = 0; p < P; p++) begin m_en[p] = '0; m_st[p] = '0; end
            m_pin = 1'b1;
        end else begin
            any = 1'b0;
            for (int p = 0; p < P; p++)
                if (m_en[p][1] && ((m_st[p] & m_en[p] & 16'h00F0) != 0)) any = 1'b1;
            if (wr && addr == 5'd18 && port < P) m_en[port] = wdata & 16'h00F2;
            if (rd) begin
                e = 16'h0;
                if (port < P) begin
                    if (addr == 5'd18)      e = m_en[port];
                    else if (addr == 5'd19) e = m_st[port];
                end
                expq.push_back(e);
                tagq.push_back(cur_tag);
                if (addr == 5'd19 && port < P) m_st[port] = '0;
            end
            for (int p = 0; p < P; p++) begin
                ev = '0;
                ev[4] = an[p] & ~p_an[p];
                ev[5] = spd[p] ^ p_spd[p];
                ev[6] = dup[p] ^ p_dup[p];
                ev[7] = lnk[p] ^ p_lnk[p];
                m_st[p] = m_st[p] | ev;
            end
            m_pin = ~any;
        end
        p_an = an; p_spd = spd; p_dup = dup; p_lnk = lnk;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R9 shared pin", {15'b0, irq_n}, {15'b0, m_pin});
    endtask

    // monitor: compares read data one edge after each read strobe
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            logic [15:0] e;
            string       t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(t, rdata, e);
        end
    end

    task automatic wr_reg(input int p, input int a, input logic [15:0] d);
        wr = 1'b1; port = 3'(p); addr = 5'(a); wdata = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic rd_reg(input int p, input int a, input string tag);
        rd = 1'b1; port = 3'(p); addr = 5'(a); cur_tag = tag;
        tick();
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        an = '0; spd = '0; dup = '0; lnk = '0;
        wr = 1'b0; rd = 1'b0; port = '0; addr = '0; wdata = '0; cur_tag = "";
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 pin after reset", {15'b0, irq_n}, 16'h0001);
        rd_reg(0, 18, "R1 control after reset");
        rd_reg(0, 19, "R1 status after reset");

        wr_reg(0, 18, 16'hFFFF);
        rd_reg(0, 18, "R2 control keeps bits 1 and 4..7");

        lnk[0] = 1'b1;
        idle(2);
        chk("R4 link change pulls pin", {15'b0, irq_n}, 16'h0000);
        rd_reg(0, 19, "R3 R6 link bit 7 read");
        rd_reg(0, 19, "R6 cleared after read");
        tick();
        chk("R9 pin released", {15'b0, irq_n}, 16'h0001);

        spd[0] = 1'b1; dup[0] = 1'b1;
        idle(2);
        rd_reg(0, 19, "R4 speed and duplex together");
        tick();

        an[2] = 1'b1;
        idle(2);
        chk("R8 disabled port no pin", {15'b0, irq_n}, 16'h0001);
        rd_reg(2, 19, "R5 autoneg rise latched");
        an[2] = 1'b0;
        idle(2);
        rd_reg(2, 19, "R5 autoneg fall ignored");

        wr_reg(1, 18, 16'h0022);
        dup[1] = 1'b1;
        idle(2);
        chk("R8 masked duplex no pin", {15'b0, irq_n}, 16'h0001);
        spd[1] = 1'b1;
        idle(2);
        chk("R8 unmasked speed pin", {15'b0, irq_n}, 16'h0000);
        rd_reg(1, 19, "R8 masked bit still latched");
        tick();

        lnk[0] = 1'b0;
        tick();
        lnk[0] = 1'b1;
        rd_reg(0, 19, "R7 read with coinciding event");
        rd_reg(0, 19, "R7 coinciding event kept");
        tick();

        wr_reg(3, 18, 16'h00F2);
        lnk[3] = 1'b1; lnk[0] = 1'b0;
        idle(2);
        rd_reg(0, 19, "R9 first port read");
        tick();
        chk("R9 other port still pending", {15'b0, irq_n}, 16'h0000);
        rd_reg(3, 19, "R9 second port read");
        tick();
        chk("R9 all cleared", {15'b0, irq_n}, 16'h0001);

        wr_reg(3, 19, 16'hFFFF);
        rd_reg(3, 19, "R10 status write ignored");
        wr_reg(3, 5, 16'hFFFF);
        rd_reg(3, 5, "R10 other address reads zero");
        rd_reg(3, 18, "R10 control untouched");
        rd_reg(7, 18, "R10 port out of range");

        rd_reg(3, 18, "R11 read data");
        idle(3);
        chk("R11 read data held", rdata, 16'h00F2);

        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule